// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits in a memory controller and brings a DDR SDRAM device from power-on to a state where ordinary read and write traffic may start. After a synchronous reset it keeps the clock-enable pin low for a settling interval. The length of that interval is a number of microseconds multiplied by the clock frequency in MHz. When the interval ends it raises clock enable and places a NOP on the command bus. It then issues, one command at a time, a precharge of all banks, an extended mode register write that switches the delay-locked loop on, a mode register write that resets the delay-locked loop, a second precharge of all banks, a configurable number of auto refreshes, and a final mode register write that leaves the delay-locked loop running.

Between commands the bus carries NOP for exactly the parameterized recovery time of the command just issued. A separate lock timer starts at the delay-locked-loop reset. The ready flag stays low until both the final recovery time and the lock interval have run out. The operating-parameter fields for both mode registers come from input ports. The block forces only the bits that control the delay-locked loop.

Top module: `sdram_powerup_seq`

## Requirements
- R1: After reset is released, `cke` stays low for exactly SETTLE_CYC = CLK_MHZ*SETTLE_US cycles, counting the first cycle after release, and then stays high.
- R2: While `cke` is low the bus carries only NOP. The first cycle with `cke` high also carries NOP, and the first precharge-all follows in the next cycle.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and MODE REGISTER SET=0000. NOP and AUTO REFRESH carry `ba`=0 and `addr`=0.
- R4: Each precharge drives `ba`=0 and `addr` with only bit 10 set (all banks).
- R5: The extended mode register write drives `ba`=1 and `addr`=`ext_mode` with bit 0 forced to 0 (delay-locked loop enabled).
- R6: The first mode register write drives `ba`=0 and `addr`=`op_mode` with bit 8 forced to 1 (delay-locked loop reset).
- R7: The non-NOP commands come in this order: precharge, extended mode write, mode write, precharge, N_REFRESH auto refreshes (N_REFRESH at least 2), final mode write. No command follows it.
- R8: The final mode register write drives `ba`=0 and `addr`=`op_mode` with bit 8 forced to 0.
- R9: The next command follows a precharge after exactly T_RP cycles, a mode or extended mode write after exactly T_MRD cycles, and an auto refresh after exactly T_RFC cycles. All cycles in between carry NOP.
- R10: `done` rises in cycle max(m2 + T_MRD, m1 + T_DLL_LOCK), where m1 and m2 are the cycles of the first and final mode register writes.
- R11: Once `done` is high it stays high, `cke` stays high and the bus carries NOP.
- R12: Asserting `rst` at any point returns `cke` and `done` to low and the bus to NOP. After release the whole sequence restarts from the settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | ROW_W | Operating-parameter field for the mode register |
| ext_mode | input | ROW_W | Field for the extended mode register |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Address bus |
| done | output | 1 | Device ready for normal traffic |

## Verification
The bench builds the block with CLK_MHZ=250 and SETTLE_US=1, which gives a 250-cycle settling delay. It sets T_RP=3, T_MRD=2 and T_RFC=7, with three refreshes. With these values every spacing check is short, and the three refreshes show that the refresh count is really taken from the parameter and not fixed at two. T_DLL_LOCK keeps its default of 200, which is far longer than the tail of the command sequence, so the lock timer alone decides when `done` rises. The two runs use `op_mode` values with bit 8 clear and with bit 8 set, and `ext_mode` values with bit 0 set and clear, so both directions of each forced bit are seen.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [3:0] {
    ST_SETTLE,
    ST_NOP,
    ST_PRE_A,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE_B,
    ST_REF,
    ST_MRS_RUN,
    ST_WAIT,
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int A_DLL_RST   = 8;   // mode register: delay-locked loop reset
  localparam int A_ALL_BANKS = 10;  // precharge: all banks
  localparam int E_DLL_OFF   = 0;   // extended register: 1 disables the loop

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)
      count <= CNT_W'(RST_VAL);
    else if (load)
      count <= load_val;
    else if (count != '0)
      count <= count - 1'b1;
  end

  assign zero = (count == '0);

  // An expired timer stays expired until it is loaded again.
  assert_timer_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);

endmodule

// File: rtl/pwrup_cmd_encode.sv
module pwrup_cmd_encode
  import pwrup_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  step_e             step,
  input  logic [ROW_W-1:0]  op_mode,
  input  logic [ROW_W-1:0]  ext_mode,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ROW_W-1:0]  addr
);

  logic [ROW_W-1:0] pre_addr;
  logic [ROW_W-1:0] emrs_addr;
  logic [ROW_W-1:0] mrs_dll_addr;
  logic [ROW_W-1:0] mrs_run_addr;

  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    assign pre_addr[i]     = (i == A_ALL_BANKS);
    assign emrs_addr[i]    = (i == E_DLL_OFF) ? 1'b0 : ext_mode[i];
    assign mrs_dll_addr[i] = (i == A_DLL_RST) ? 1'b1 : op_mode[i];
    assign mrs_run_addr[i] = (i == A_DLL_RST) ? 1'b0 : op_mode[i];
  end

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    unique case (step)
      ST_PRE_A, ST_PRE_B: begin
        cmd  = CMD_PRE;
        addr = pre_addr;
      end
      ST_EMRS: begin
        cmd  = CMD_MRS;
        ba   = BA_W'(1);
        addr = emrs_addr;
      end
      ST_MRS_DLL: begin
        cmd  = CMD_MRS;
        addr = mrs_dll_addr;
      end
      ST_MRS_RUN: begin
        cmd  = CMD_MRS;
        addr = mrs_run_addr;
      end
      ST_REF:  cmd = CMD_REF;
      default: cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import pwrup_pkg::*;
#(
  parameter int CLK_MHZ    = 250,
  parameter int SETTLE_US  = 200,
  parameter int ROW_W      = 13,
  parameter int BA_W       = 2,
  parameter int T_MRD      = 2,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 10,
  parameter int N_REFRESH  = 2,
  parameter int T_DLL_LOCK = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] op_mode,
  input  logic [ROW_W-1:0] ext_mode,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             done
);

  // All T_* values must be at least 2 and N_REFRESH at least 2.
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int MAX_WAIT   = max2(max2(SETTLE_CYC, T_DLL_LOCK),
                                   max2(T_RFC, max2(T_RP, T_MRD)));
  localparam int CNT_W      = $clog2(MAX_WAIT + 1);
  localparam int REF_W      = $clog2(N_REFRESH + 1);

  localparam logic [CNT_W-1:0] W_MRD  = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] W_RP   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] W_RFC  = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] W_LOCK = CNT_W'(T_DLL_LOCK - 2);

  step_e            st, st_nxt, ret, ret_nxt;
  logic [REF_W-1:0] ref_left;
  logic             wait_load, wait_zero, lock_load, lock_zero;
  logic [CNT_W-1:0] wait_val;

  logic [3:0]       cmd_nxt, cmd_q;
  logic [BA_W-1:0]  ba_nxt;
  logic [ROW_W-1:0] addr_nxt;

  // Wait timer: the reset value covers the settling delay.
  pwrup_wait_timer #(.CNT_W(CNT_W), .RST_VAL(SETTLE_CYC - 1)) u_wait (
    .clk(clk), .rst(rst), .load(wait_load), .load_val(wait_val), .zero(wait_zero)
  );

  // Lock timer, started by the delay-locked-loop reset.
  pwrup_wait_timer #(.CNT_W(CNT_W), .RST_VAL(0)) u_lock (
    .clk(clk), .rst(rst), .load(lock_load), .load_val(W_LOCK), .zero(lock_zero)
  );

  always_comb begin
    st_nxt    = st;
    ret_nxt   = ret;
    wait_load = 1'b0;
    wait_val  = '0;
    lock_load = 1'b0;
    unique case (st)
      ST_SETTLE: if (wait_zero) st_nxt = ST_NOP;
      ST_NOP:    st_nxt = ST_PRE_A;
      ST_PRE_A: begin
        st_nxt = ST_WAIT; ret_nxt = ST_EMRS;    wait_load = 1'b1; wait_val = W_RP;
      end
      ST_EMRS: begin
        st_nxt = ST_WAIT; ret_nxt = ST_MRS_DLL; wait_load = 1'b1; wait_val = W_MRD;
      end
      ST_MRS_DLL: begin
        st_nxt = ST_WAIT; ret_nxt = ST_PRE_B;   wait_load = 1'b1; wait_val = W_MRD;
        lock_load = 1'b1;
      end
      ST_PRE_B: begin
        st_nxt = ST_WAIT; ret_nxt = ST_REF;     wait_load = 1'b1; wait_val = W_RP;
      end
      ST_REF: begin
        st_nxt    = ST_WAIT;
        ret_nxt   = (ref_left > REF_W'(1)) ? ST_REF : ST_MRS_RUN;
        wait_load = 1'b1;
        wait_val  = W_RFC;
      end
      ST_MRS_RUN: begin
        st_nxt = ST_WAIT; ret_nxt = ST_DONE;    wait_load = 1'b1; wait_val = W_MRD;
      end
      ST_WAIT:
        if (wait_zero && (ret != ST_DONE || lock_zero)) st_nxt = ret;
      default: st_nxt = ST_DONE;
    endcase
  end

  pwrup_cmd_encode #(.ROW_W(ROW_W), .BA_W(BA_W)) u_enc (
    .step(st_nxt), .op_mode(op_mode), .ext_mode(ext_mode),
    .cmd(cmd_nxt), .ba(ba_nxt), .addr(addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_SETTLE;
      ret      <= ST_SETTLE;
      ref_left <= REF_W'(N_REFRESH);
      cke      <= 1'b0;
      done     <= 1'b0;
      cmd_q    <= CMD_NOP;
      ba       <= '0;
      addr     <= '0;
    end else begin
      st    <= st_nxt;
      ret   <= ret_nxt;
      if (st == ST_REF) ref_left <= ref_left - 1'b1;
      cke   <= (st_nxt != ST_SETTLE);
      done  <= (st_nxt == ST_DONE);
      cmd_q <= cmd_nxt;
      ba    <= ba_nxt;
      addr  <= addr_nxt;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  assert_cke_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  assert_cke_low_nop_R2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd_q == CMD_NOP));
  assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> addr[A_ALL_BANKS]);
  assert_refresh_count_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MRS_RUN) |-> (ref_left == '0));
  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> lock_zero);
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && cke));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;

  localparam int CLK_MHZ = 250, SETTLE_US = 1, ROW_W = 13, BA_W = 2;
  localparam int T_MRD = 2, T_RP = 3, T_RFC = 7, N_REF = 3, T_LOCK = 200;
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int N_CMD = N_REF + 5;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  // Expected command table: {cmd, ba}, and the spacing to the next command.
  localparam logic [5:0] EXP_CMD [0:7] = '{
    {PRE, 2'd0}, {MRS, 2'd1}, {MRS, 2'd0}, {PRE, 2'd0},
    {REF, 2'd0}, {REF, 2'd0}, {REF, 2'd0}, {MRS, 2'd0}};
  localparam int EXP_GAP [0:6] = '{T_RP, T_MRD, T_MRD, T_RP, T_RFC, T_RFC, T_RFC};

  logic clk = 1'b0, rst = 1'b1;
  logic [ROW_W-1:0] op_mode = '0, ext_mode = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  always #2 clk = ~clk;

  sdram_powerup_seq #(
    .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .ROW_W(ROW_W), .BA_W(BA_W),
    .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .N_REFRESH(N_REF), .T_DLL_LOCK(T_LOCK)
  ) i_sdram_powerup_seq (
    .clk(clk), .rst(rst), .op_mode(op_mode), .ext_mode(ext_mode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .done(done)
  );

  int checks = 0, fails = 0;
  int cyc, nrec, done_cyc, cke_first, low_cmds, post_bad;
  bit seen_high, nop_at_rise;
  logic [3:0] rec_cmd [0:15];
  logic [BA_W-1:0] rec_ba [0:15];
  logic [ROW_W-1:0] rec_addr [0:15];
  int rec_cyc [0:15];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: samples outputs one time unit after each falling edge.
  always @(negedge clk) begin
    #1;
    if (rst) begin
      cyc = 0; nrec = 0; done_cyc = -1; cke_first = -1;
      low_cmds = 0; post_bad = 0; seen_high = 0; nop_at_rise = 0;
    end else begin
      if (!seen_high && cke) begin
        seen_high = 1; cke_first = cyc;
        nop_at_rise = ({cs_n, ras_n, cas_n, we_n} == NOP);
      end
      if (!cke && {cs_n, ras_n, cas_n, we_n} != NOP) low_cmds++;
      if (done_cyc >= 0 && (!done || !cke || {cs_n, ras_n, cas_n, we_n} != NOP))
        post_bad++;
      if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
        if (nrec < 16) begin
          rec_cmd[nrec] = {cs_n, ras_n, cas_n, we_n};
          rec_ba[nrec] = ba; rec_addr[nrec] = addr; rec_cyc[nrec] = cyc;
        end
        nrec++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      cyc++;
    end
  end

  function automatic logic [ROW_W-1:0] exp_addr(input int i,
      input logic [ROW_W-1:0] op, input logic [ROW_W-1:0] ext);
    case (i)
      0, 3:    return ROW_W'(13'h400);
      1:       return ext & ~ROW_W'(1);
      2:       return op | ROW_W'(13'h100);
      7:       return op & ~ROW_W'(13'h100);
      default: return '0;
    endcase
  endfunction

  function automatic string addr_tag(input int i);
    case (i)
      0, 3:    return "R4";
      1:       return "R5";
      2:       return "R6";
      7:       return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic apply_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(!cke, "R12", "cke low in reset", cke, 0);
    check(!done, "R12", "done low in reset", done, 0);
    check({cs_n, ras_n, cas_n, we_n} == NOP, "R12", "NOP in reset",
          {cs_n, ras_n, cas_n, we_n}, NOP);
  endtask

  task automatic run_full(input logic [ROW_W-1:0] op, input logic [ROW_W-1:0] ext);
    int exp_done;
    op_mode = op; ext_mode = ext;
    apply_reset();
    @(negedge clk); rst = 1'b0;
    while (done_cyc < 0) @(negedge clk);
    repeat (20) @(negedge clk);
    #3;
    check(cke_first == SETTLE_CYC, "R1", "cycles with cke low", cke_first, SETTLE_CYC);
    check(low_cmds == 0, "R2", "commands while cke low", low_cmds, 0);
    check(nop_at_rise, "R2", "NOP when cke rises", nop_at_rise, 1);
    check(nrec == N_CMD, "R7", "command count", nrec, N_CMD);
    if (nrec == N_CMD) begin
      check(rec_cyc[0] == cke_first + 1, "R2", "first precharge cycle",
            rec_cyc[0], cke_first + 1);
      for (int i = 0; i < N_CMD; i++) begin
        check({rec_cmd[i], rec_ba[i]} == EXP_CMD[i], "R7", $sformatf("cmd/ba %0d", i),
              {rec_cmd[i], rec_ba[i]}, EXP_CMD[i]);
        check(rec_addr[i] == exp_addr(i, op, ext), addr_tag(i),
              $sformatf("addr %0d", i), rec_addr[i], exp_addr(i, op, ext));
        if (i < N_CMD - 1)
          check(rec_cyc[i+1] - rec_cyc[i] == EXP_GAP[i], "R9",
                $sformatf("gap after %0d", i), rec_cyc[i+1] - rec_cyc[i], EXP_GAP[i]);
      end
      exp_done = (rec_cyc[7] + T_MRD > rec_cyc[2] + T_LOCK) ? rec_cyc[7] + T_MRD
                                                            : rec_cyc[2] + T_LOCK;
      check(done_cyc == exp_done, "R10", "done cycle", done_cyc, exp_done);
    end
    check(post_bad == 0, "R11", "activity after done", post_bad, 0);
  endtask

  initial begin
    run_full(13'h0032, 13'h0001);
    // Reset in the middle of the refreshes, then a full run with new fields.
    apply_reset();
    @(negedge clk); rst = 1'b0;
    while (nrec < 5) @(negedge clk);
    apply_reset();
    run_full(13'h01A5, 13'h0042);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule